// File: doc/BRIEF.md
# Inter-processor and Timer Interrupt Unit

This block keeps the interrupt state for two interrupt sources in a small multiprocessor: inter-processor interrupts (IPIs) that one processor sends to others, and a periodic timer interrupt delivered to every processor. Each source has a pending vector with one bit per processor. Each pending bit drives that processor's interrupt line directly.

Software changes the state through a write port. A packed control word can post IPIs, clear IPIs and clear timer interrupts in a single write. Three dedicated registers take a plain processor mask for one operation each. A tick input marks a timer period for all processors. Posting an IPI that is already pending, or clearing one that is not pending, changes nothing and raises a warning pulse. Malformed writes raise error pulses. Reads are combinational and return the pending vectors together with the identity of the reading processor.

Top module: `ipi_timer_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both pending vectors, all interrupt lines and all four status pulses are zero after that edge.
- R2: A write to address 0 (control word) sets the IPI pending bit, and raises `ipi_irq`, for each present processor whose bit is set in wdata[15:12] (bit 12 is processor 0). The change is visible after the clock edge that samples the write.
- R3: A control-word write clears the IPI pending bits selected by wdata[11:8] and the timer pending bits selected by wdata[7:4]. A timer bit that is selected but not pending stays zero and raises no pulse.
- R4: When a single control-word write both posts and clears the IPI of the same processor, the clear wins: the bit ends at zero and `warn_empty_clear` stays low.
- R5: Posting an IPI to a processor whose IPI is already pending leaves the state unchanged. `warn_dup_post` is high for exactly the one cycle after the write.
- R6: Clearing an IPI for a processor with no pending IPI leaves the state unchanged. `warn_empty_clear` is high for exactly the one cycle after the write.
- R7: A control-word write with wdata[28] set and no other effective field changes nothing and raises no error. A control-word write with no effective field and wdata[28] clear raises `err_unsupported` for one cycle. So does a write to any address from 4 to 7. Neither kind of write changes state.
- R8: Address 1 posts IPIs, address 2 clears IPIs and address 3 clears timer interrupts, each using the processor mask in wdata[3:0]. When the effective mask is zero, `err_zero_mask` pulses for one cycle and no state changes.
- R9: `tick` sets the timer pending bit of every present processor. If a timer clear comes in the same cycle as a tick, the tick wins.
- R10: `rdata` is combinational in `addr`. Address 0 returns the IPI vector in bits 11:8, the timer vector in bits 7:4 and `req_cpu` in bits 1:0. Address 4 returns the IPI vector in bits 3:0. Address 5 returns the timer vector in bits 3:0. All other bits, and all other addresses, read zero.
- R11: With `NUM_CPUS` below 4, mask bits for absent processors are ignored. The pending bits and lines of absent processors stay zero, and a mask that selects only absent processors counts as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| req_cpu | input | 2 | Identity of the processor issuing the access |
| tick | input | 1 | Timer period pulse |
| rdata | output | 32 | Read data |
| ipi_irq | output | 4 | IPI line per processor |
| tmr_irq | output | 4 | Timer interrupt line per processor |
| warn_dup_post | output | 1 | Pulse: IPI posted to a processor that already had one pending |
| warn_empty_clear | output | 1 | Pulse: IPI cleared for a processor that had none pending |
| err_zero_mask | output | 1 | Pulse: dedicated register written with an empty effective mask |
| err_unsupported | output | 1 | Pulse: write carried no supported operation |

## Verification
The bench targets the cases where two operations meet.

- Post and clear of the same IPI in one control word: if the order were wrong, the line would stay high or a false empty-clear warning would fire.
- A tick together with a timer clear: if the precedence were reversed, a period would be lost.
- Redundant posts and clears: a design that toggled on these would flip lines, and one without the warning pulse logic would stay silent.
- Error handling: the acknowledgement-only bit 28 must not be flagged, and empty masks must not touch state.
- Fewer processors: a second instance built for two processors must never drive the lines of absent processors.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    localparam int MAX_CPUS   = 4;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 32;
    localparam int ID_W       = 2;

    localparam int POST_LSB   = 12;
    localparam int IPICLR_LSB = 8;
    localparam int TMRCLR_LSB = 4;
    localparam int ACK_BIT    = 28;

    typedef logic [MAX_CPUS-1:0] cpu_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL     = 3'd0,
        REG_IPI_SET  = 3'd1,
        REG_IPI_CLR  = 3'd2,
        REG_TMR_CLR  = 3'd3,
        REG_IPI_STAT = 3'd4,
        REG_TMR_STAT = 3'd5
    } reg_addr_e;

    typedef struct packed {
        cpu_vec_t ipi_set;
        cpu_vec_t ipi_clr;
        cpu_vec_t tmr_clr;
        logic     unsupported;
        logic     zero_mask;
    } op_t;

    function automatic cpu_vec_t present_mask(input int n);
        cpu_vec_t m;
        for (int i = 0; i < MAX_CPUS; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/ipu_decode.sv
module ipu_decode
    import ipu_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output op_t               op
);
    localparam cpu_vec_t PRESENT = present_mask(NUM_CPUS);

    cpu_vec_t low_mask;
    cpu_vec_t post_f, iclr_f, tclr_f;
    logic     unused_upper;

    assign low_mask = wdata[MAX_CPUS-1:0] & PRESENT;
    assign post_f   = wdata[POST_LSB   +: MAX_CPUS] & PRESENT;
    assign iclr_f   = wdata[IPICLR_LSB +: MAX_CPUS] & PRESENT;
    assign tclr_f   = wdata[TMRCLR_LSB +: MAX_CPUS] & PRESENT;
    assign unused_upper = ^{wdata[DATA_W-1:ACK_BIT+1], wdata[ACK_BIT-1:POST_LSB+MAX_CPUS]};

    always_comb begin
        op = '0;
        if (wr_en) begin
            case (addr)
                REG_CTRL: begin
                    op.ipi_set     = post_f;
                    op.ipi_clr     = iclr_f;
                    op.tmr_clr     = tclr_f;
                    op.unsupported = (post_f == '0) && (iclr_f == '0) &&
                                     (tclr_f == '0) && !wdata[ACK_BIT];
                end
                REG_IPI_SET: begin
                    op.ipi_set   = low_mask;
                    op.zero_mask = (low_mask == '0);
                end
                REG_IPI_CLR: begin
                    op.ipi_clr   = low_mask;
                    op.zero_mask = (low_mask == '0);
                end
                REG_TMR_CLR: begin
                    op.tmr_clr   = low_mask;
                    op.zero_mask = (low_mask == '0);
                end
                default: op.unsupported = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ipu_pending.sv
module ipu_pending
    import ipu_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter bit SET_WINS = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  cpu_vec_t set_mask,
    input  cpu_vec_t clr_mask,
    output cpu_vec_t pend,
    output logic     dup_set,
    output logic     miss_clr
);
    localparam cpu_vec_t PRESENT = present_mask(NUM_CPUS);

    cpu_vec_t nxt;

    generate
        if (SET_WINS) begin : g_set_wins
            assign nxt      = (pend & ~clr_mask) | set_mask;
            assign miss_clr = |(clr_mask & ~pend);

            assert_tick_R9: assert property (@(posedge clk) disable iff (rst)
                (|set_mask) |=> ((pend & $past(set_mask)) == $past(set_mask)));
            assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
                (|(clr_mask & ~set_mask)) |=> ((pend & $past(clr_mask & ~set_mask)) == '0));
        end else begin : g_clr_wins
            assign nxt      = (pend | set_mask) & ~clr_mask;
            assign miss_clr = |(clr_mask & ~(pend | set_mask));

            assert_set_R2: assert property (@(posedge clk) disable iff (rst)
                (|(set_mask & ~clr_mask)) |=>
                ((pend & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));
            assert_clr_wins_R4: assert property (@(posedge clk) disable iff (rst)
                (|clr_mask) |=> ((pend & $past(clr_mask)) == '0));
        end
    endgenerate

    assign dup_set = |(set_mask & pend);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= nxt & PRESENT;
    end

    assert_reset_R1: assert property (@(posedge clk) rst |=> (pend == '0));
endmodule

// File: rtl/ipu_readmux.sv
module ipu_readmux
    import ipu_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  cpu_vec_t          ipi_pend,
    input  cpu_vec_t          tmr_pend,
    input  logic [ID_W-1:0]   req_cpu,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: begin
                rdata[IPICLR_LSB +: MAX_CPUS] = ipi_pend;
                rdata[TMRCLR_LSB +: MAX_CPUS] = tmr_pend;
                rdata[ID_W-1:0]               = req_cpu;
            end
            REG_IPI_STAT: rdata[MAX_CPUS-1:0] = ipi_pend;
            REG_TMR_STAT: rdata[MAX_CPUS-1:0] = tmr_pend;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/ipi_timer_unit.sv
module ipi_timer_unit
    import ipu_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    input  logic [1:0]        req_cpu,
    input  logic              tick,
    output logic [31:0]       rdata,
    output logic [3:0]        ipi_irq,
    output logic [3:0]        tmr_irq,
    output logic              warn_dup_post,
    output logic              warn_empty_clear,
    output logic              err_zero_mask,
    output logic              err_unsupported
);
    localparam cpu_vec_t PRESENT = present_mask(NUM_CPUS);

    op_t      op;
    cpu_vec_t ipi_pend, tmr_pend, tick_mask;
    logic     ipi_dup, ipi_miss;
    logic     unused_tmr_dup, unused_tmr_miss;

    assign tick_mask = tick ? PRESENT : '0;

    ipu_decode #(.NUM_CPUS(NUM_CPUS)) u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .op    (op)
    );

    ipu_pending #(.NUM_CPUS(NUM_CPUS), .SET_WINS(1'b0)) u_ipi (
        .clk      (clk),
        .rst      (rst),
        .set_mask (op.ipi_set),
        .clr_mask (op.ipi_clr),
        .pend     (ipi_pend),
        .dup_set  (ipi_dup),
        .miss_clr (ipi_miss)
    );

    ipu_pending #(.NUM_CPUS(NUM_CPUS), .SET_WINS(1'b1)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .set_mask (tick_mask),
        .clr_mask (op.tmr_clr),
        .pend     (tmr_pend),
        .dup_set  (unused_tmr_dup),
        .miss_clr (unused_tmr_miss)
    );

    ipu_readmux u_read (
        .addr     (addr),
        .ipi_pend (ipi_pend),
        .tmr_pend (tmr_pend),
        .req_cpu  (req_cpu),
        .rdata    (rdata)
    );

    assign ipi_irq = ipi_pend;
    assign tmr_irq = tmr_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            warn_dup_post    <= 1'b0;
            warn_empty_clear <= 1'b0;
            err_zero_mask    <= 1'b0;
            err_unsupported  <= 1'b0;
        end else begin
            warn_dup_post    <= ipi_dup;
            warn_empty_clear <= ipi_miss;
            err_zero_mask    <= op.zero_mask;
            err_unsupported  <= op.unsupported;
        end
    end

    assert_unsup_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        err_unsupported |-> $stable(ipi_irq));
    assert_zero_mask_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        err_zero_mask |-> $stable(ipi_irq));
    assert_dup_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        warn_dup_post |-> (ipi_irq != '0));
    assert_absent_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        ((ipi_irq | tmr_irq) & ~PRESENT) == '0);
endmodule

// File: tb/tb_ipi_timer_unit.sv
`timescale 1ns/1ps
module tb_ipi_timer_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  req_cpu = '0;
    logic        tick = 1'b0;

    logic [31:0] rdata, rdata2;
    logic [3:0]  ipi_irq, tmr_irq, ipi2, tmr2;
    logic        wdup, wempty, ezero, eunsup;
    logic        wdup2, wempty2, ezero2, eunsup2;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ipi_timer_unit dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .req_cpu(req_cpu), .tick(tick), .rdata(rdata), .ipi_irq(ipi_irq),
        .tmr_irq(tmr_irq), .warn_dup_post(wdup), .warn_empty_clear(wempty),
        .err_zero_mask(ezero), .err_unsupported(eunsup)
    );

    ipi_timer_unit #(.NUM_CPUS(2)) dut_n2 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .req_cpu(req_cpu), .tick(tick), .rdata(rdata2), .ipi_irq(ipi2),
        .tmr_irq(tmr2), .warn_dup_post(wdup2), .warn_empty_clear(wempty2),
        .err_zero_mask(ezero2), .err_unsupported(eunsup2)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; wdata = '0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] id);
        addr = a; req_cpu = id;
        #1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(3'd4, 2'd0);
        chk("R1", "ipi_irq", {28'd0, ipi_irq}, 32'h0);
        chk("R1", "tmr_irq", {28'd0, tmr_irq}, 32'h0);
        chk("R1", "pulses", {28'd0, wdup, wempty, ezero, eunsup}, 32'h0);
        chk("R1", "ipi read", rdata, 32'h0);
    endtask

    task automatic t_post();
        wr(3'd0, 32'h0000_5000, 1'b0);
        chk("R2", "ipi after post 0,2", {28'd0, ipi_irq}, 32'h5);
        chk("R2", "no dup warn", {31'd0, wdup}, 32'h0);
        rd(3'd0, 2'd2);
        chk("R10", "ctrl read", rdata, 32'h0000_0502);
    endtask

    task automatic t_dup();
        wr(3'd0, 32'h0000_1000, 1'b0);
        chk("R5", "dup warn", {31'd0, wdup}, 32'h1);
        chk("R5", "ipi unchanged", {28'd0, ipi_irq}, 32'h5);
        @(negedge clk);
        chk("R5", "dup warn one cycle", {31'd0, wdup}, 32'h0);
    endtask

    task automatic t_clear();
        wr(3'd0, 32'h0000_0100, 1'b0);
        chk("R3", "ipi after clear 0", {28'd0, ipi_irq}, 32'h4);
        chk("R3", "no empty warn", {31'd0, wempty}, 32'h0);
        wr(3'd0, 32'h0000_0200, 1'b0);
        chk("R6", "empty warn", {31'd0, wempty}, 32'h1);
        chk("R6", "ipi unchanged", {28'd0, ipi_irq}, 32'h4);
        @(negedge clk);
        chk("R6", "empty warn one cycle", {31'd0, wempty}, 32'h0);
    endtask

    task automatic t_post_clear();
        wr(3'd0, 32'h0000_8800, 1'b0);
        chk("R4", "clear wins", {28'd0, ipi_irq}, 32'h4);
        chk("R4", "no warnings", {30'd0, wdup, wempty}, 32'h0);
    endtask

    task automatic t_timer();
        pulse_tick();
        chk("R9", "tick sets all", {28'd0, tmr_irq}, 32'hF);
        rd(3'd0, 2'd1);
        chk("R10", "ctrl read with timer", rdata, 32'h0000_04F1);
        wr(3'd0, 32'h0000_0030, 1'b0);
        chk("R3", "timer clear 0,1", {28'd0, tmr_irq}, 32'hC);
        rd(3'd5, 2'd0);
        chk("R10", "timer read", rdata, 32'h0000_000C);
        wr(3'd0, 32'h0000_0030, 1'b0);
        chk("R3", "timer clear of idle bits", {28'd0, tmr_irq}, 32'hC);
        chk("R3", "no pulses", {28'd0, wdup, wempty, ezero, eunsup}, 32'h0);
        wr(3'd3, 32'h0000_0004, 1'b1);
        chk("R9", "tick beats clear", {28'd0, tmr_irq}, 32'hF);
    endtask

    task automatic t_direct();
        wr(3'd1, 32'h0000_0003, 1'b0);
        chk("R8", "direct post", {28'd0, ipi_irq}, 32'h7);
        wr(3'd2, 32'h0000_0004, 1'b0);
        chk("R8", "direct clear", {28'd0, ipi_irq}, 32'h3);
        rd(3'd4, 2'd0);
        chk("R10", "ipi read", rdata, 32'h0000_0003);
        wr(3'd1, 32'h0000_0000, 1'b0);
        chk("R8", "zero mask err", {31'd0, ezero}, 32'h1);
        chk("R8", "zero mask no change", {28'd0, ipi_irq}, 32'h3);
        wr(3'd3, 32'h0000_0010, 1'b0);
        chk("R8", "zero low nibble err", {31'd0, ezero}, 32'h1);
        chk("R8", "timer kept", {28'd0, tmr_irq}, 32'hF);
    endtask

    task automatic t_unsup();
        wr(3'd0, 32'h1000_0000, 1'b0);
        chk("R7", "ack bit no error", {31'd0, eunsup}, 32'h0);
        chk("R7", "ack bit no change", {24'd0, ipi_irq, tmr_irq}, 32'h3F);
        wr(3'd0, 32'h0000_0001, 1'b0);
        chk("R7", "empty ctrl flagged", {31'd0, eunsup}, 32'h1);
        wr(3'd6, 32'h0000_000F, 1'b0);
        chk("R7", "unmapped flagged", {31'd0, eunsup}, 32'h1);
        chk("R7", "unmapped no change", {24'd0, ipi_irq, tmr_irq}, 32'h3F);
        rd(3'd6, 2'd3);
        chk("R10", "unmapped read", rdata, 32'h0);
    endtask

    task automatic t_narrow();
        chk("R11", "two-cpu timer", {28'd0, tmr2}, 32'h3);
        chk("R11", "two-cpu ipi", {28'd0, ipi2}, 32'h3);
        wr(3'd1, 32'h0000_000C, 1'b0);
        chk("R11", "absent-only mask err", {31'd0, ezero2}, 32'h1);
        chk("R11", "absent lines low", {28'd0, ipi2}, 32'h3);
        chk("R11", "four-cpu takes it", {28'd0, ipi_irq}, 32'hF);
        rd(3'd4, 2'd0);
        chk("R11", "two-cpu read", rdata2, 32'h0000_0003);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_post();
        t_dup();
        t_clear();
        t_post_clear();
        t_timer();
        t_direct();
        t_unsup();
        t_narrow();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule